// File: doc/BRIEF.md
# Hashed Global-History Branch Predictor

This block predicts the direction of conditional branches. It keeps one short global history of recent branch directions and a small table of 2-bit saturating counters. To pick a counter, it XORs the history with a few scattered bits of the branch address. A front end asks for a prediction by presenting the branch address with a valid strobe. In the same cycle it gets back a taken/not-taken answer and the table index that was used. It keeps that index with the branch.

When the branch resolves, the back end returns the stored index and the real outcome, and the selected counter is trained. The history only ever holds predicted directions. Each prediction shifts its own guess in, and the real outcome is never written back into the history.

The history width, the address width and the address bit feeding each history bit are all parameters. The table depth follows from the history width.

Top module: `gh_branch_predictor`

## Requirements
- R1: The prediction index bit k equals history bit k XOR address bit TAP_POS[k]. With the default taps, index bits 3, 2, 1 and 0 use address bits 10, 4, 3 and 1.
- R2: The prediction is taken (1) when the selected counter holds 2 or 3, and not taken (0) when it holds 0 or 1. The prediction and its index are combinational in the same cycle.
- R3: On a clock edge with the prediction strobe high, the history shifts one place toward its MSB and drops its old MSB. The predicted direction of that cycle enters bit 0, with 1 meaning taken.
- R4: On a clock edge with the prediction strobe low, the history keeps its value.
- R5: A resolution never changes the history, whatever its outcome.
- R6: A resolution with outcome taken increments the counter at the returned index, saturating at 3.
- R7: A resolution with outcome not taken decrements the counter at the returned index, saturating at 0.
- R8: A resolution changes only the counter at its returned index. Every other counter keeps its value.
- R9: After reset the history is all zeros and every counter holds 1 (weakly not taken).
- R10: A prediction and a resolution in the same cycle both take effect. The prediction reads the counter value from before that cycle's update, even when both use the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | A branch asks for a prediction this cycle |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_index | output | HIST_W | Table index used for this prediction |
| res_valid | input | 1 | A branch resolves this cycle |
| res_index | input | HIST_W | Index saved at prediction time |
| res_taken | input | 1 | Actual direction, 1 = taken |

## Verification
The bench builds the block with its defaults: a 4-bit history, a 16-bit address and taps at bits 10, 4, 3 and 1. That gives only 16 counters and 16 history states, so the bench can sweep every index directly after reset. It can also drive each counter through both saturation limits.

A long pseudo-random run then mixes predictions and resolutions freely, including same-index collisions. That run reaches every history value and every counter state, and the bench compares each cycle against an arithmetic model of the history and the counters.

// File: rtl/gh_bp_pkg.sv
package gh_bp_pkg;
  // two-bit saturating step: up when taken, down when not
  function automatic logic [1:0] sat_step(input logic [1:0] cur, input logic up);
    if (up) return (cur == 2'b11) ? cur : cur + 2'b01;
    else    return (cur == 2'b00) ? cur : cur - 2'b01;
  endfunction

  localparam logic [1:0] CTR_RESET = 2'b01;
endpackage

// File: rtl/gh_index_hash.sv
module gh_index_hash #(
  parameter int HIST_W = 4,
  parameter int PC_W   = 16,
  parameter logic [HIST_W*8-1:0] TAP_POS = {8'd10, 8'd4, 8'd3, 8'd1}
) (
  input  logic [HIST_W-1:0] hist,
  input  logic [PC_W-1:0]   pc,
  output logic [HIST_W-1:0] idx
);
  for (genvar k = 0; k < HIST_W; k++) begin : g_bit
    localparam int POS = int'(TAP_POS[k*8 +: 8]);
    assign idx[k] = hist[k] ^ pc[POS];
  end
endmodule

// File: rtl/gh_history.sv
module gh_history #(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
  end
endmodule

// File: rtl/gh_counter_table.sv
module gh_counter_table
  import gh_bp_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [1:0]         rd_ctr,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_up,
  output logic [DEPTH*2-1:0] ctr_flat
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [1:0] ctr_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        ctr_q <= CTR_RESET;
      else if (wr_en && (wr_idx == IDX_W'(e)))
        ctr_q <= sat_step(ctr_q, wr_up);
    end
    assign ctr_flat[e*2 +: 2] = ctr_q;
  end

  assign rd_ctr = ctr_flat[{rd_idx, 1'b0} +: 2];
endmodule

// File: rtl/gh_branch_predictor.sv
module gh_branch_predictor #(
  parameter int HIST_W = 4,
  parameter int PC_W   = 16,
  parameter logic [HIST_W*8-1:0] TAP_POS = {8'd10, 8'd4, 8'd3, 8'd1}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_valid,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_index,
  input  logic              res_valid,
  input  logic [HIST_W-1:0] res_index,
  input  logic              res_taken
);
  localparam int DEPTH = 1 << HIST_W;

  // named internal events for the checker
  logic [HIST_W-1:0]  hist_q;
  logic [1:0]         sel_ctr;
  logic [DEPTH*2-1:0] ctr_flat;
  logic               hist_shift;
  logic               tbl_write;

  assign hist_shift = pred_valid;
  assign tbl_write  = res_valid;

  gh_index_hash #(.HIST_W(HIST_W), .PC_W(PC_W), .TAP_POS(TAP_POS)) u_hash (
    .hist (hist_q),
    .pc   (pred_pc),
    .idx  (pred_index)
  );

  gh_counter_table #(.IDX_W(HIST_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (pred_index),
    .rd_ctr   (sel_ctr),
    .wr_en    (tbl_write),
    .wr_idx   (res_index),
    .wr_up    (res_taken),
    .ctr_flat (ctr_flat)
  );

  assign pred_taken = sel_ctr[1];

  gh_history #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (hist_shift),
    .bit_in   (pred_taken),
    .hist     (hist_q)
  );
endmodule

// File: rtl/gh_bp_checker.sv
module gh_bp_checker #(
  parameter int HIST_W = 4,
  parameter int PC_W   = 16,
  parameter logic [HIST_W*8-1:0] TAP_POS = {8'd10, 8'd4, 8'd3, 8'd1},
  localparam int DEPTH = 1 << HIST_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pred_valid,
  input logic [PC_W-1:0]    pred_pc,
  input logic               pred_taken,
  input logic [HIST_W-1:0]  pred_index,
  input logic               res_valid,
  input logic [HIST_W-1:0]  res_index,
  input logic               res_taken,
  input logic [HIST_W-1:0]  hist_q,
  input logic [DEPTH*2-1:0] ctr_flat
);
  logic [1:0] at_res;
  logic [1:0] at_pred;
  logic [HIST_W-1:0] tap_bits;
  assign at_res  = ctr_flat[{res_index, 1'b0} +: 2];
  assign at_pred = ctr_flat[{pred_index, 1'b0} +: 2];
  for (genvar k = 0; k < HIST_W; k++) begin : g_tap
    assign tap_bits[k] = pred_pc[int'(TAP_POS[k*8 +: 8])];
  end

  // R1
  index_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_index ^ hist_q) == tap_bits);

  // R2
  taken_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken == (at_pred >= 2'd2));

  // R3
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(pred_taken)});

  // R4
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |=> $stable(hist_q));

  // R6
  ctr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken) |=>
      ctr_flat[{$past(res_index), 1'b0} +: 2] ==
        (($past(at_res) == 2'd3) ? 2'd3 : $past(at_res) + 2'd1));

  // R7
  ctr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken) |=>
      ctr_flat[{$past(res_index), 1'b0} +: 2] ==
        (($past(at_res) == 2'd0) ? 2'd0 : $past(at_res) - 2'd1));

  // R8
  ctr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(ctr_flat));
endmodule

bind gh_branch_predictor gh_bp_checker #(
  .HIST_W(HIST_W), .PC_W(PC_W), .TAP_POS(TAP_POS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pred_valid (pred_valid),
  .pred_pc    (pred_pc),
  .pred_taken (pred_taken),
  .pred_index (pred_index),
  .res_valid  (res_valid),
  .res_index  (res_index),
  .res_taken  (res_taken),
  .hist_q     (hist_q),
  .ctr_flat   (ctr_flat)
);

// File: tb/gh_branch_predictor_test.sv
module gh_branch_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pred_valid = 1'b0;
  logic [15:0] pred_pc = '0;
  logic        pred_taken;
  logic [3:0]  pred_index;
  logic        res_valid = 1'b0;
  logic [3:0]  res_index = '0;
  logic        res_taken = 1'b0;

  int checks = 0;
  int fails  = 0;

  logic [3:0] m_hist;
  logic [1:0] m_ctr [16];
  logic [31:0] rng = 32'h1234_5679;

  always #2.5 clk = ~clk;

  gh_branch_predictor uut (
    .clk(clk), .rst_n(rst_n),
    .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_index(pred_index),
    .res_valid(res_valid), .res_index(res_index), .res_taken(res_taken)
  );

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [3:0] model_index(input logic [3:0] h, input logic [15:0] pc);
    return h ^ {pc[10], pc[4], pc[3], pc[1]};
  endfunction

  // places a 4-bit value onto the tapped address bits
  function automatic logic [15:0] pc_for(input logic [3:0] v, input logic [15:0] junk);
    logic [15:0] p = junk;
    p[10] = v[3]; p[4] = v[2]; p[3] = v[1]; p[1] = v[0];
    return p;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cycle: drive after negedge, check before posedge, advance model
  task automatic step(input logic pv, input logic [15:0] pc, input logic rv,
                      input logic [3:0] ri, input logic rt, input string tag);
    logic [3:0] e_idx;
    logic       e_tk;
    pred_valid = pv; pred_pc = pc;
    res_valid = rv; res_index = ri; res_taken = rt;
    #1;
    e_idx = model_index(m_hist, pc);
    e_tk  = m_ctr[e_idx] >= 2'd2;
    check({tag, " index"}, 32'(pred_index), 32'(e_idx));
    check({tag, " taken"}, 32'(pred_taken), 32'(e_tk));
    if (pv) m_hist = {m_hist[2:0], e_tk};
    if (rv) begin
      if (rt) m_ctr[ri] = (m_ctr[ri] == 2'd3) ? 2'd3 : m_ctr[ri] + 2'd1;
      else    m_ctr[ri] = (m_ctr[ri] == 2'd0) ? 2'd0 : m_ctr[ri] - 2'd1;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    m_hist = '0;
    for (int i = 0; i < 16; i++) m_ctr[i] = 2'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 R1 R2: every index reachable from the reset history, all weakly not taken
    for (int i = 0; i < 16; i++) begin
      step(1'b0, pc_for(4'(i), 16'h5AA5), 1'b0, 4'd0, 1'b0, "R9 reset sweep");
      check("R9 reset counter", 32'(pred_taken), 32'd0);
    end

    // R6: saturate index 6 upward, R8 keeps neighbours at 1
    for (int n = 0; n < 5; n++) step(1'b0, 16'h0, 1'b1, 4'd6, 1'b1, "R6 inc");
    step(1'b0, pc_for(4'd6, 16'h0), 1'b0, 4'd0, 1'b0, "R6 saturate high");
    check("R6 taken at 3", 32'(pred_taken), 32'd1);
    step(1'b0, pc_for(4'd7, 16'h0), 1'b0, 4'd0, 1'b0, "R8 neighbour");
    check("R8 neighbour untouched", 32'(pred_taken), 32'd0);

    // R7: one step down stays taken, then saturate at 0
    step(1'b0, 16'h0, 1'b1, 4'd6, 1'b0, "R7 dec");
    step(1'b0, pc_for(4'd6, 16'h0), 1'b0, 4'd0, 1'b0, "R7 at 2");
    check("R7 value 2 still taken", 32'(pred_taken), 32'd1);
    for (int n = 0; n < 4; n++) step(1'b0, 16'h0, 1'b1, 4'd6, 1'b0, "R7 dec");
    step(1'b0, 16'h0, 1'b1, 4'd6, 1'b1, "R7 up from 0");
    step(1'b0, pc_for(4'd6, 16'h0), 1'b0, 4'd0, 1'b0, "R7 floor");
    check("R7 floor then one up is 1", 32'(pred_taken), 32'd0);

    // R5: resolutions alone leave the history alone (seen via index)
    step(1'b0, 16'h0, 1'b1, 4'd3, 1'b1, "R5 resolve only");
    check("R5 history still zero", 32'(pred_index), 32'd0);

    // R10: index 9 from 1 to 2 while predicting it in the same cycle
    step(1'b1, pc_for(4'd9, 16'h0), 1'b1, 4'd9, 1'b1, "R10 collide");
    step(1'b0, pc_for(4'd9 ^ {3'b000, 1'b0}, 16'h0), 1'b0, 4'd0, 1'b0, "R10 after");

    // R3 R4: history shift with a known taken prediction
    for (int n = 0; n < 3; n++) step(1'b0, 16'h0, 1'b1, 4'd0, 1'b1, "R3 prime");
    step(1'b1, pc_for(m_hist, 16'h0), 1'b0, 4'd0, 1'b0, "R3 shift taken");
    step(1'b0, 16'h0, 1'b0, 4'd0, 1'b0, "R4 hold");

    // mixed pseudo-random traffic, all requirements against the model
    for (int c = 0; c < 4000; c++) begin
      rng = next_rng(rng);
      step(rng[0], rng[31:16], rng[1] | rng[2], rng[7:4], rng[3], "R1-mix R3 R6 R7 R10");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule